// File: doc/BRIEF.md
# Descriptor Ring Address Sequencer

This block walks a circular list of DMA descriptors for one traffic direction. Each entry is 8 bytes, made of four 16-bit words, so consecutive entries sit 8 bytes apart. The block holds the ring base address and the ring length. It also keeps a current descriptor address, a precomputed next descriptor address and the index of the current entry.

After a start pulse the sequencer reads the status word of the current entry over a simple request/acknowledge memory port. It then inspects the ownership bit of that word. When the controller owns the entry, the sequencer raises `owned` and waits for the surrounding engine to signal `done`. It then writes the status word back once, with the ownership bit cleared, which hands the entry to the host. After that it moves on to the next entry, wrapping at the end of the ring. When the host still owns the entry, the sequencer parks on it without writing anything and reads it again on each `poll` pulse.

The ring length can be set in two ways. The initialization path clamps the value to at most 128 entries. A direct register write takes any value up to 65535. A length of zero is refused: a start pulse then raises an error flag and the sequencer stays idle.

Top module: `descRingSeq`

## Requirements
- R1: A synchronous reset clears `curAddr`, `nextAddr`, `entryIdx`, `owned`, `lenErr` and `memReq` to zero, and the sequencer issues no memory request until a start pulse arrives.
- R2: A start pulse in idle with a nonzero ring length sets `curAddr` to the base address and `entryIdx` to 0. It sets `nextAddr` to base+8, or to base when the length is 1.
- R3: A status fetch is a read (`memWe`=0) at `curAddr`+2. `memReq`, `memWe` and `memAddr` stay stable until the cycle in which `memAck` is high.
- R4: The ownership bit is bit 15 of the status word, and 1 means the controller owns the entry. When a read returns bit 15 set, `owned` is high from the cycle after the acknowledge.
- R5: When a read returns bit 15 clear, `owned` stays low and no write is issued. The sequencer stays on the entry and reads the same address again after each `poll` pulse.
- R6: A `done` pulse while `owned` is high causes exactly one write to `curAddr`+2. The written data is the fetched status word with bit 15 cleared. After that write is acknowledged, `curAddr` takes the old `nextAddr`, `entryIdx` increments, `nextAddr` advances by 8, and the next entry is fetched.
- R7: When `entryIdx` equals length−1, `nextAddr` equals the base address. Releasing that entry returns `curAddr` to the base and `entryIdx` to 0.
- R8: A length written through the initialization path is clamped to 128: a value above 128 gives a ring of 128 entries.
- R9: A length written directly is used unclamped, for any value from 1 to 65535.
- R10: A start pulse with ring length 0 raises `lenErr` and leaves the sequencer idle with no memory request. A later start with a nonzero length clears `lenErr`.
- R11: A write to memory only ever follows a read that returned bit 15 set, and every write carries bit 15 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgBaseWe | input | 1 | Load ring base address |
| cfgBaseData | input | ADDR_W | Ring base address |
| cfgLenWe | input | 1 | Direct ring length write, unclamped |
| cfgLenData | input | LEN_W | Direct ring length |
| initLenWe | input | 1 | Initialization-path length write, clamped to 128 |
| initLenData | input | LEN_W | Initialization-path length |
| start | input | 1 | Begin walking the ring from the base |
| poll | input | 1 | Re-read a host-owned entry |
| done | input | 1 | Controller has finished with the owned entry |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the status word |
| memWData | output | DATA_W | Write data |
| memAck | input | 1 | One-cycle acknowledge of the request |
| memRData | input | DATA_W | Read data, valid with memAck |
| curAddr | output | ADDR_W | Current descriptor address |
| nextAddr | output | ADDR_W | Next descriptor address |
| entryIdx | output | LEN_W | Current entry index |
| owned | output | 1 | Controller owns the current entry |
| lenErr | output | 1 | Start refused because the length is zero |

## Verification
The assertions assume that `memAck` is pulsed for one cycle only while `memReq` is high. They also assume that `memRData` is valid in that cycle, and that the base and length are not rewritten while the ring is being walked. The bench keeps to these rules. A responder acknowledges only an outstanding request, after a random delay of 0 to 2 cycles, and drops the acknowledge on the next cycle. The base and length are changed only before a start pulse. Random base addresses are aligned to 8 bytes, and random lengths are kept small so that wrap-around happens often.

// File: rtl/descRingPkg.sv
package descRingPkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_OWNED,
    S_RELEASE
  } seqState_t;

  typedef struct packed {
    logic load;     // copy base into current, compute next
    logic capture;  // latch fetched status word
    logic advance;  // step current to next
  } pathCtl_t;
endpackage

// File: rtl/descRingPath.sv
module descRingPath
  import descRingPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 16,
  parameter int DATA_W      = 16,
  parameter int OWN_BIT     = 15,
  parameter int INIT_MAX    = 128,
  parameter int ENTRY_BYTES = 8,
  parameter int STAT_OFS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgBaseWe,
  input  logic [ADDR_W-1:0] cfgBaseData,
  input  logic              cfgLenWe,
  input  logic [LEN_W-1:0]  cfgLenData,
  input  logic              initLenWe,
  input  logic [LEN_W-1:0]  initLenData,
  input  pathCtl_t          ctl,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [LEN_W-1:0]  entryIdx,
  output logic              lenZero,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData
);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(ENTRY_BYTES);
  localparam logic [ADDR_W-1:0] OFS      = ADDR_W'(STAT_OFS);
  localparam logic [LEN_W-1:0]  INIT_CAP = LEN_W'(INIT_MAX);
  localparam logic [DATA_W-1:0] OWN_MASK = DATA_W'(1) << OWN_BIT;

  logic [ADDR_W-1:0] baseReg;
  logic [LEN_W-1:0]  ringLen;
  logic [DATA_W-1:0] statReg;
  logic [LEN_W-1:0]  lastIdx;
  logic [LEN_W-1:0]  idxStep;
  logic [LEN_W-1:0]  cappedLen;

  assign lastIdx   = ringLen - LEN_W'(1);
  assign idxStep   = (entryIdx == lastIdx) ? '0 : entryIdx + LEN_W'(1);
  assign cappedLen = (initLenData > INIT_CAP) ? INIT_CAP : initLenData;
  assign lenZero   = (ringLen == '0);
  assign memAddr   = curAddr + OFS;
  assign memWData  = statReg & ~OWN_MASK;

  // configuration registers; direct write wins over the init path
  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg <= '0;
      ringLen <= '0;
    end else begin
      if (cfgBaseWe) baseReg <= cfgBaseData;
      if (cfgLenWe)       ringLen <= cfgLenData;
      else if (initLenWe) ringLen <= cappedLen;
    end
  end

  // current / next address and index
  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr  <= '0;
      nextAddr <= '0;
      entryIdx <= '0;
    end else if (ctl.load) begin
      curAddr  <= baseReg;
      entryIdx <= '0;
      nextAddr <= (lastIdx == '0) ? baseReg : baseReg + STEP;
    end else if (ctl.advance) begin
      curAddr  <= nextAddr;
      entryIdx <= idxStep;
      nextAddr <= (idxStep == lastIdx) ? baseReg : nextAddr + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              statReg <= '0;
    else if (ctl.capture) statReg <= memRData;
  end
endmodule

// File: rtl/descRingCtrl.sv
module descRingCtrl
  import descRingPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     poll,
  input  logic     done,
  input  logic     memAck,
  input  logic     ownFlag,
  input  logic     lenZero,
  output pathCtl_t ctl,
  output logic     memReq,
  output logic     memWe,
  output logic     owned,
  output logic     lenErr
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    unique case (state)
      S_IDLE: if (start && !lenZero) begin
        ctl.load  = 1'b1;
        stateNext = S_FETCH;
      end
      S_FETCH: if (memAck) begin
        ctl.capture = 1'b1;
        stateNext   = ownFlag ? S_OWNED : S_WAIT;
      end
      S_WAIT:  if (poll) stateNext = S_FETCH;
      S_OWNED: if (done) stateNext = S_RELEASE;
      S_RELEASE: if (memAck) begin
        ctl.advance = 1'b1;
        stateNext   = S_FETCH;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign memReq = (state == S_FETCH) || (state == S_RELEASE);
  assign memWe  = (state == S_RELEASE);
  assign owned  = (state == S_OWNED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      lenErr <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && start) lenErr <= lenZero;
    end
  end
endmodule

// File: rtl/descRingSeq.sv
module descRingSeq
  import descRingPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 16,
  parameter int DATA_W      = 16,
  parameter int OWN_BIT     = 15,
  parameter int INIT_MAX    = 128,
  parameter int ENTRY_BYTES = 8,
  parameter int STAT_OFS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgBaseWe,
  input  logic [ADDR_W-1:0] cfgBaseData,
  input  logic              cfgLenWe,
  input  logic [LEN_W-1:0]  cfgLenData,
  input  logic              initLenWe,
  input  logic [LEN_W-1:0]  initLenData,
  input  logic              start,
  input  logic              poll,
  input  logic              done,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [LEN_W-1:0]  entryIdx,
  output logic              owned,
  output logic              lenErr
);
  pathCtl_t ctl;
  logic     lenZero;

  descRingCtrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .poll    (poll),
    .done    (done),
    .memAck  (memAck),
    .ownFlag (memRData[OWN_BIT]),
    .lenZero (lenZero),
    .ctl     (ctl),
    .memReq  (memReq),
    .memWe   (memWe),
    .owned   (owned),
    .lenErr  (lenErr)
  );

  descRingPath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .OWN_BIT(OWN_BIT),
    .INIT_MAX(INIT_MAX), .ENTRY_BYTES(ENTRY_BYTES), .STAT_OFS(STAT_OFS)
  ) u_path (
    .clk         (clk),
    .rst         (rst),
    .cfgBaseWe   (cfgBaseWe),
    .cfgBaseData (cfgBaseData),
    .cfgLenWe    (cfgLenWe),
    .cfgLenData  (cfgLenData),
    .initLenWe   (initLenWe),
    .initLenData (initLenData),
    .ctl         (ctl),
    .memRData    (memRData),
    .curAddr     (curAddr),
    .nextAddr    (nextAddr),
    .entryIdx    (entryIdx),
    .lenZero     (lenZero),
    .memAddr     (memAddr),
    .memWData    (memWData)
  );
endmodule

// File: rtl/descRingChk.sv
module descRingChk #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int OWN_BIT = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWData,
  input logic [DATA_W-1:0] memRData,
  input logic [ADDR_W-1:0] curAddr,
  input logic [ADDR_W-1:0] nextAddr,
  input logic              owned,
  input logic              lenErr
);
  logic lastReadOwn;

  always_ff @(posedge clk) begin
    if (rst) lastReadOwn <= 1'b0;
    else if (memReq && memAck && !memWe) lastReadOwn <= memRData[OWN_BIT];
    else if (memReq && memAck && memWe)  lastReadOwn <= 1'b0;
  end

  assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
    memReq && !memAck |=> memReq && $stable(memWe) && $stable(memAddr));

  assert_owned_after_fetch_R4: assert property (@(posedge clk) disable iff (rst)
    memReq && memAck && !memWe && memRData[OWN_BIT] |=> owned);

  assert_host_entry_idle_R5: assert property (@(posedge clk) disable iff (rst)
    memReq && memAck && !memWe && !memRData[OWN_BIT] |=> !owned && !memReq);

  assert_advance_R6: assert property (@(posedge clk) disable iff (rst)
    memReq && memAck && memWe |=> curAddr == $past(nextAddr));

  assert_write_only_owned_R11: assert property (@(posedge clk) disable iff (rst)
    memReq && memWe |-> lastReadOwn && !memWData[OWN_BIT]);

  assert_owned_no_req_R4: assert property (@(posedge clk) disable iff (rst)
    owned |-> !memReq);

  assert_len_err_idle_R10: assert property (@(posedge clk) disable iff (rst)
    lenErr |-> !memReq && !owned);
endmodule

bind descRingSeq descRingChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OWN_BIT(OWN_BIT)
) u_chk (
  .clk(clk), .rst(rst), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .memWData(memWData), .memRData(memRData),
  .curAddr(curAddr), .nextAddr(nextAddr), .owned(owned), .lenErr(lenErr)
);

// File: tb/test_descRingSeq.sv
`timescale 1ns/1ps
module test_descRingSeq;
  localparam int AW = 24;
  localparam int LW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfgBaseWe = 0, cfgLenWe = 0, initLenWe = 0;
  logic [AW-1:0] cfgBaseData = '0;
  logic [LW-1:0] cfgLenData = '0, initLenData = '0;
  logic          start = 0, poll = 0, done = 0;
  logic          memReq, memWe, memAck = 0;
  logic [AW-1:0] memAddr, curAddr, nextAddr;
  logic [DW-1:0] memWData, memRData = '0;
  logic [LW-1:0] entryIdx;
  logic          owned, lenErr;

  always #2.5 clk = ~clk;

  descRingSeq i_descRingSeq (.*);

  int checks = 0, fails = 0;
  int readCount = 0, writeCount = 0, delayCnt = 0;
  logic ownReply = 1'b1;
  logic [AW-1:0] lastRdAddr, lastWrAddr;
  logic [DW-1:0] lastRd, lastWrData;
  bit finished = 0;

  // memory responder
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (delayCnt == 0) begin
        memAck = 1'b1;
        if (memWe) begin
          writeCount++; lastWrAddr = memAddr; lastWrData = memWData;
        end else begin
          readCount++; lastRdAddr = memAddr;
          memRData = {ownReply, 15'($urandom)};
          lastRd = memRData;
        end
        delayCnt = $urandom % 3;
      end else delayCnt--;
    end
  end

  function automatic logic [AW-1:0] expAddr(logic [AW-1:0] b, int idx);
    return b + AW'(idx * 8);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(int rT);
    wait (readCount >= rT);
    @(negedge clk); #1;
  endtask

  task automatic setCfg(logic [AW-1:0] b, logic [LW-1:0] l, bit viaInit);
    @(negedge clk); #1;
    cfgBaseWe = 1; cfgBaseData = b;
    if (viaInit) begin initLenWe = 1; initLenData = l; end
    else begin cfgLenWe = 1; cfgLenData = l; end
    @(negedge clk); #1;
    cfgBaseWe = 0; cfgLenWe = 0; initLenWe = 0;
  endtask

  task automatic doStart();
    int rT = readCount + 1;
    start = 1; @(negedge clk); #1; start = 0;
    settle(rT);
  endtask

  task automatic doRelease();
    int rT = readCount + 1;
    int wT = writeCount + 1;
    done = 1; @(negedge clk); #1; done = 0;
    wait (writeCount >= wT);
    settle(rT);
  endtask

  task automatic doPoll();
    int rT = readCount + 1;
    poll = 1; @(negedge clk); #1; poll = 0;
    settle(rT);
  endtask

  // walk n entries of a ring starting from index 0, checking each step
  task automatic walk(logic [AW-1:0] b, int len, int n, string req);
    for (int k = 0; k < n; k++) begin
      logic [DW-1:0] rd = lastRd;
      logic [AW-1:0] ca = curAddr;
      doRelease();
      check(lastWrAddr == ca + 2, "R6 write addr", lastWrAddr, ca + 2);
      check(lastWrData == (rd & 16'h7fff), "R6 write data", lastWrData, rd & 16'h7fff);
      check(curAddr == expAddr(b, (k + 1) % len), req, curAddr, expAddr(b, (k + 1) % len));
      check(entryIdx == LW'((k + 1) % len), req, entryIdx, (k + 1) % len);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int w0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk); #1;
    rst = 0;
    @(negedge clk); #1;
    // R1 reset state
    check(curAddr == 0 && nextAddr == 0 && entryIdx == 0, "R1 addresses", curAddr, 0);
    check(!memReq && !owned && !lenErr, "R1 outputs", {memReq, owned, lenErr}, 0);
    repeat (5) @(negedge clk); #1;
    check(!memReq && readCount == 0, "R1 idle until start", readCount, 0);

    // R10 zero length
    setCfg(24'h001000, 16'd0, 0);
    start = 1; @(negedge clk); #1; start = 0;
    repeat (4) @(negedge clk); #1;
    check(lenErr == 1, "R10 lenErr", lenErr, 1);
    check(!memReq && readCount == 0, "R10 no request", readCount, 0);

    // R2/R3/R4 start with length 4
    setCfg(24'h002000, 16'd4, 0);
    ownReply = 1;
    doStart();
    check(lenErr == 0, "R10 lenErr cleared", lenErr, 0);
    check(curAddr == 24'h002000 && entryIdx == 0, "R2 load base", curAddr, 24'h002000);
    check(nextAddr == 24'h002008, "R2 next", nextAddr, 24'h002008);
    check(lastRdAddr == 24'h002002, "R3 fetch addr", lastRdAddr, 24'h002002);
    check(owned == 1, "R4 owned", owned, 1);
    // R6/R7 walk through wrap
    walk(24'h002000, 4, 6, "R7 wrap walk");

    // R5 host-owned entry
    ownReply = 0;
    doRelease();
    check(owned == 0, "R5 not owned", owned, 0);
    w0 = writeCount;
    repeat (6) @(negedge clk); #1;
    check(writeCount == w0 && !memReq, "R5 no write while waiting", writeCount, w0);
    doPoll();
    check(lastRdAddr == curAddr + 2 && owned == 0, "R5 repoll same entry", lastRdAddr, curAddr + 2);
    check(writeCount == w0, "R11 no write to host entry", writeCount, w0);
    ownReply = 1;
    doPoll();
    check(owned == 1, "R5 owned after poll", owned, 1);
    done = 1; @(negedge clk); #1; done = 0;
    wait (writeCount > w0); settle(readCount + 1);

    // R2 length one: next equals base
    rst = 1; @(negedge clk); #1; rst = 0;
    setCfg(24'h003000, 16'd1, 0);
    doStart();
    check(nextAddr == 24'h003000, "R2 len1 next", nextAddr, 24'h003000);
    walk(24'h003000, 1, 2, "R7 len1 wrap");

    // R8 init path clamps 200 to 128
    rst = 1; @(negedge clk); #1; rst = 0;
    setCfg(24'h010000, 16'd200, 1);
    doStart();
    walk(24'h010000, 128, 127, "R8 init walk");
    check(nextAddr == 24'h010000, "R8 clamp wrap next", nextAddr, 24'h010000);
    walk(24'h010000, 1, 1, "R8 back to base");

    // R9 direct 300 not clamped
    rst = 1; @(negedge clk); #1; rst = 0;
    setCfg(24'h020000, 16'd300, 0);
    doStart();
    walk(24'h020000, 300, 129, "R9 direct walk");
    check(entryIdx == 129, "R9 index beyond 128", entryIdx, 129);

    // random rings
    for (int t = 0; t < 20; t++) begin
      logic [AW-1:0] b = AW'({$urandom} & 32'h00fffff8);
      int len = 1 + ($urandom % 6);
      rst = 1; @(negedge clk); #1; rst = 0;
      setCfg(b, LW'(len), 0);
      doStart();
      check(curAddr == b, "R2 random base", curAddr, b);
      walk(b, len, len + 2, "R7 random walk");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule